// File: doc/BRIEF.md
# Line-Cycle Energy Accumulator

This block integrates a signed apparent-power sample stream over a window made of a whole number of line half-cycles, so that calibration software can compare energy readings taken over exactly repeatable intervals. Zero-crossing detection lies outside the block. Each phase supplies a one-cycle crossing pulse, and every pulse from a selected phase moves the window one half-cycle closer to its end.

A three-bit phase-select input chooses which phases contribute crossings. The same bits, registered, are driven out as per-phase enables for the zero-crossing, timeout and period-measurement logic. When the programmed number of half-cycles has elapsed, the upper bits of the running sum are captured into the line-energy output and a one-cycle completion pulse is raised. The window then restarts from zero. The mode is always running and has no enable.

Top module: `line_energy_acc`

## Requirements
- R1: While reset is high and in the first cycle after it, `line_energy` is 0, `done` is 0 and `phase_en` is 0. The half-cycle reload value is `HC_RESET` (default 4).
- R2: `phase_en[i]` equals `phase_sel[i]` from the previous clock cycle. Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.
- R3: A crossing pulse `zx[i]` counts only when `phase_sel[i]` is 1. Pulses from deselected phases do not shorten the window.
- R4: Pulses from several selected phases in the same cycle each count as one half-cycle. Any pulses beyond those needed to end the window are discarded.
- R5: When `pwr_vld` is 1, `pwr_sample` is added to the running sum as a signed two's-complement value. A sample that arrives in the cycle that ends a window belongs to that window.
- R6: In the cycle where the counted half-cycles reach the programmed number, the next clock cycle shows `line_energy` equal to bits [ACC_W-1:ACC_W-24] of the window's sum, with `done` at 1 for that one cycle. The next window starts from a zero sum and the full reload count.
- R7: A cycle with `hc_load` at 1 does the following:
  - It sets the reload value and the remaining count to `hc_count`, with 0 treated as 1.
  - It clears the sum.
  - It ignores that cycle's sample and crossings.
  - It never raises `done`.
- R8: Between completions, `line_energy` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_sample | input | PWR_W (24) | Signed apparent-power sample |
| pwr_vld | input | 1 | Sample strobe |
| zx | input | NPH (3) | Per-phase zero-crossing pulses |
| phase_sel | input | NPH (3) | Phase selection for counting and enables |
| hc_count | input | CNT_W (16) | Half-cycles per window |
| hc_load | input | 1 | Load `hc_count` and restart the window |
| line_energy | output | OUT_W (24) | Latched upper bits of the last window's sum |
| done | output | 1 | One-cycle window-complete pulse |
| phase_en | output | NPH (3) | Registered per-phase function enables |

## Verification
The bench sweeps all eight phase selections against several half-cycle counts, including 0, 1, 2, 3 and 7, with dense random crossings and signed samples. These cases cover the following faults:
- A design that counted deselected phases would close windows early and latch a small sum.
- A design that treated simultaneous crossings as one would close windows late.
- A design that carried excess crossings into the next window would shorten that window.
- A design that dropped the sample from the terminal cycle would latch a value off by that sample.
- A design that kept the sum across a reload would mix windows.
- A design that let a count of zero through would stall or close on every cycle.

// File: rtl/lea_pkg.sv
package lea_pkg;
  parameter int MAX_PH = 8;

  function automatic int unsigned ones(input logic [MAX_PH-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_PH; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/lea_zx_counter.sv
module lea_zx_counter #(
  parameter int NPH      = 3,
  parameter int CNT_W    = 16,
  parameter int HC_RESET = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPH-1:0]   zx,
  input  logic [NPH-1:0]   sel,
  input  logic [CNT_W-1:0] hc_count,
  input  logic             hc_load,
  output logic             fire
);
  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(HC_RESET);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0]          count_q, reload_q, load_val, hits;
  logic [lea_pkg::MAX_PH-1:0] live;

  assign live     = lea_pkg::MAX_PH'(zx & sel);
  assign hits     = CNT_W'(lea_pkg::ones(live));
  assign load_val = (hc_count == '0) ? ONE : hc_count;
  assign fire     = !hc_load && (hits >= count_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= RST_CNT;
      reload_q <= RST_CNT;
    end else if (hc_load) begin
      count_q  <= load_val;
      reload_q <= load_val;
    end else if (fire) begin
      count_q  <= reload_q;
    end else begin
      count_q  <= count_q - hits;
    end
  end

  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    count_q != '0); // R6
  AST_DESEL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!hc_load && (zx & sel) == '0) |=> count_q == $past(count_q)); // R3
  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (rst)
    (hc_load && hc_count != '0) |=> count_q == $past(hc_count)); // R7
endmodule

// File: rtl/lea_accum.sv
module lea_accum #(
  parameter int PWR_W = 24,
  parameter int ACC_W = 40,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PWR_W-1:0] sample,
  input  logic             vld,
  input  logic             clr,
  input  logic             fire,
  output logic [OUT_W-1:0] line_energy,
  output logic             done
);
  localparam int EXT_W = ACC_W - PWR_W;

  logic [ACC_W-1:0] acc_q, addend, acc_nx;

  assign addend = vld ? {{EXT_W{sample[PWR_W-1]}}, sample} : '0;
  assign acc_nx = acc_q + addend;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q       <= '0;
      line_energy <= '0;
      done        <= 1'b0;
    end else if (clr) begin
      acc_q <= '0;
      done  <= 1'b0;
    end else if (fire) begin
      acc_q       <= '0;
      line_energy <= acc_nx[ACC_W-1 -: OUT_W];
      done        <= 1'b1;
    end else begin
      acc_q <= acc_nx;
      done  <= 1'b0;
    end
  end

  AST_HOLD_LE: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(line_energy)); // R8
  AST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_q == '0 && !done)); // R7
  AST_FIRE_RESTART: assert property (@(posedge clk) disable iff (rst)
    (fire && !clr) |=> (acc_q == '0 && done)); // R6
endmodule

// File: rtl/line_energy_acc.sv
module line_energy_acc #(
  parameter int NPH      = 3,
  parameter int PWR_W    = 24,
  parameter int ACC_W    = 40,
  parameter int OUT_W    = 24,
  parameter int CNT_W    = 16,
  parameter int HC_RESET = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PWR_W-1:0] pwr_sample,
  input  logic             pwr_vld,
  input  logic [NPH-1:0]   zx,
  input  logic [NPH-1:0]   phase_sel,
  input  logic [CNT_W-1:0] hc_count,
  input  logic             hc_load,
  output logic [OUT_W-1:0] line_energy,
  output logic             done,
  output logic [NPH-1:0]   phase_en
);
  logic fire;

  always_ff @(posedge clk) begin
    if (rst) phase_en <= '0;
    else     phase_en <= phase_sel;
  end

  lea_zx_counter #(.NPH(NPH), .CNT_W(CNT_W), .HC_RESET(HC_RESET)) u_cnt (
    .clk(clk), .rst(rst), .zx(zx), .sel(phase_sel),
    .hc_count(hc_count), .hc_load(hc_load), .fire(fire)
  );

  lea_accum #(.PWR_W(PWR_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_acc (
    .clk(clk), .rst(rst), .sample(pwr_sample), .vld(pwr_vld),
    .clr(hc_load), .fire(fire), .line_energy(line_energy), .done(done)
  );

  AST_PEN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    phase_en == $past(phase_sel)); // R2
  AST_LOAD_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    hc_load |=> !done); // R7
endmodule

// File: tb/line_energy_acc_bench.sv
module line_energy_acc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] pwr_sample = '0;
  logic        pwr_vld = 1'b0;
  logic [2:0]  zx = '0, phase_sel = '0;
  logic [15:0] hc_count = '0;
  logic        hc_load = 1'b0;
  logic [23:0] line_energy;
  logic        done;
  logic [2:0]  phase_en;

  int total = 0, bad = 0;
  logic [31:0] rng = 32'h1234_5678;

  logic [39:0] m_acc = '0;
  logic [15:0] m_cnt = 16'd4, m_rel = 16'd4;
  logic [23:0] m_le = '0;
  logic        m_done = 1'b0;
  logic [2:0]  m_pen = '0;
  string       tag = "R1";

  always #4 clk = ~clk;

  line_energy_acc u_line_energy_acc (
    .clk(clk), .rst(rst), .pwr_sample(pwr_sample), .pwr_vld(pwr_vld),
    .zx(zx), .phase_sel(phase_sel), .hc_count(hc_count), .hc_load(hc_load),
    .line_energy(line_energy), .done(done), .phase_en(phase_en)
  );

  task automatic check_outputs();
    total += 3;
    if (line_energy !== m_le) begin
      bad++;
      $display("FAIL %s line_energy got=%h exp=%h", tag, line_energy, m_le);
    end
    if (done !== m_done) begin
      bad++;
      $display("FAIL %s done got=%b exp=%b", tag, done, m_done);
    end
    if (phase_en !== m_pen) begin
      bad++;
      $display("FAIL R2 phase_en got=%b exp=%b", phase_en, m_pen);
    end
  endtask

  // Apply inputs at negedge, advance the model, wait for the next negedge.
  task automatic step(input logic ld, input logic [15:0] hc,
                      input logic [2:0] z, input logic v, input logic [23:0] s);
    logic [39:0] nx;
    int          hits;
    hc_load = ld; hc_count = hc; zx = z; pwr_vld = v; pwr_sample = s;
    m_pen = phase_sel;
    if (ld) begin
      m_rel  = (hc == 0) ? 16'd1 : hc;
      m_cnt  = m_rel;
      m_acc  = '0;
      m_done = 1'b0;
      tag    = "R7";
    end else begin
      nx   = m_acc + (v ? {{16{s[23]}}, s} : 40'd0);
      hits = $countones(z & phase_sel);
      if (hits >= int'(m_cnt)) begin
        m_le   = nx[39:16];
        m_done = 1'b1;
        m_acc  = '0;
        m_cnt  = m_rel;
        tag    = "R3 R4 R5 R6";
      end else begin
        m_cnt  = m_cnt - 16'(hits);
        m_acc  = nx;
        m_done = 1'b0;
        tag    = "R3 R5 R8";
      end
    end
    @(negedge clk);
    check_outputs();
  endtask

  task automatic rnd_step();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    step(1'b0, 16'd0, rng[2:0] & rng[5:3], rng[6] | rng[7], rng[31:8]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_outputs();  // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    check_outputs();  // R1 after release

    // R1: reset reload of 4, phase A only, one crossing per cycle
    phase_sel = 3'b001;
    for (int k = 0; k < 6; k++) step(1'b0, 16'd0, 3'b001, 1'b1, 24'h10_0000);

    // R4: three simultaneous crossings against a count of 2
    phase_sel = 3'b111;
    step(1'b1, 16'd2, 3'b000, 1'b0, '0);
    step(1'b0, 16'd0, 3'b111, 1'b1, 24'hF0_0000);
    step(1'b0, 16'd0, 3'b001, 1'b1, 24'h7F_FFFF);
    step(1'b0, 16'd0, 3'b010, 1'b1, 24'h80_0000);

    // Sweep: every phase selection against several counts, including 0
    for (int sel = 0; sel < 8; sel++) begin
      foreach (hc_vals[i]) begin
        phase_sel = 3'(sel);
        step(1'b1, hc_vals[i], 3'b111, 1'b1, 24'h55_5555);
        for (int c = 0; c < 60; c++) rnd_step();
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [15:0] hc_vals [5] = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd7};

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule